// File: doc/BRIEF.md
# Edge-Interval Bit-Check Validator

This block decides whether a demodulated data stream comes from a real transmitter or is noise. A start pulse arms the check and latches the limits and the required bit count. The stream is brought into the clock domain through a flop chain. Its edges are then taken only on cycles where the check-clock enable is high, so every interval is measured in check-clock ticks.

A counter measures the time between consecutive synchronized edges. An interval is accepted when it lies inside a window set by a lower and an upper limit. A short interval fails the check on the edge that ends it. A long one fails the check on the tick where the counter reaches the upper limit, without waiting for the edge. When the required number of half-bit intervals has been accepted, the check passes. The result is held until the next start pulse.

Top module: `bitcheck_validator`

## Requirements
- R1: After reset, pass, fail and done are all low.
- R2: A start pulse with bit-count code 00 (zero bits) sets pass and done on the clock edge that captures start, with no interval measured.
- R3: The bit-count code is 2 bits wide: 01 requires 3 bits, 10 requires 6 bits and 11 requires 9 bits. Each bit is two accepted half-bit intervals. Pass rises on the tick that accepts the last required interval.
- R4: An interval is the number of check-clock ticks between two consecutive synchronized edges. It is accepted when low ≤ interval < high.
- R5: An edge that ends an interval shorter than the lower limit sets fail on that tick.
- R6: If no edge arrives, fail rises on the tick where the tick count reaches the upper limit. The longest interval that can be accepted is therefore high − 1. The same timeout runs from the start pulse until the first edge.
- R7: A lower-limit value below 10 behaves as 10.
- R8: The first edge after start is not tested against the limits; it only starts the first interval.
- R9: pass and fail stay unchanged until the next start pulse. A start pulse with a nonzero code clears done on the edge that captures it. The limits and code are captured with start.
- R10: Clock cycles without the check-clock enable neither advance the interval count nor detect edges, so pauses in the enable cannot cause a timeout.
- R11: pass and fail are never high together, and done equals pass OR fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Check-clock enable, one cycle per check tick |
| dataIn | input | 1 | Demodulated data, asynchronous |
| start | input | 1 | Single-cycle pulse that starts a new check |
| limLo | input | 6 | Lower interval limit in ticks (clamped to at least 10) |
| limHi | input | 6 | Upper limit; an interval must be below it |
| bitSel | input | 2 | Bit-count code: 00=0, 01=3, 10=6, 11=9 |
| pass | output | 1 | Check accepted, held |
| fail | output | 1 | Check rejected, held |
| done | output | 1 | A result is available |

## Verification
The assertions assume that start is a single-cycle pulse and that a result can only appear on a tick, or at once for a zero-bit request. The stimulus therefore raises start for exactly one cycle, just after a tick. It changes dataIn only just after a tick, so every edge reaches the synchronizer well before the next tick samples it. The check-clock enable is a regular one-in-four pattern, paused only in a deliberate stretch, which keeps the tick counts that the bench model predicts identical to those the design sees.

// File: rtl/bitcheck_pkg.sv
package bitcheck_pkg;

  localparam int HALF_W = 5;

  typedef struct packed {
    logic load;  // capture configuration and clear measurement
    logic run;   // measurement active
  } ctlStrobe_t;

  typedef struct packed {
    logic goodEdge;  // interval inside window
    logic badEdge;   // interval too short
    logic tooLate;   // count reached upper limit
    logic enough;    // accepted interval would complete the target
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_PASSED,
    ST_FAILED
  } chkState_t;

  // Number of half-bit intervals required for a bit-count code
  function automatic logic [HALF_W-1:0] halvesFor(input logic [1:0] code);
    case (code)
      2'b01:   halvesFor = HALF_W'(6);
      2'b10:   halvesFor = HALF_W'(12);
      2'b11:   halvesFor = HALF_W'(18);
      default: halvesFor = '0;
    endcase
  endfunction

endpackage

// File: rtl/bitcheck_datapath.sv
module bitcheck_datapath
  import bitcheck_pkg::*;
#(
  parameter int LIM_W       = 6,
  parameter int LIM_FLOOR   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             dataIn,
  input  logic [LIM_W-1:0] limLo,
  input  logic [LIM_W-1:0] limHi,
  input  logic [1:0]       bitSel,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        st
);

  localparam int CNT_W = LIM_W + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncBit;
  logic                   lastSample;
  logic                   seenFirst;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       nextCnt;
  logic [HALF_W-1:0]      halves;
  logic [HALF_W-1:0]      target;
  logic [LIM_W-1:0]       loReg;
  logic [LIM_W-1:0]       hiReg;
  logic [LIM_W-1:0]       loClamped;
  logic                   tickLive;
  logic                   edgeSeen;
  logic                   inWindow;

  // Synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= dataIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], dataIn};
    end
  endgenerate

  assign syncBit = syncChain[SYNC_STAGES-1];

  always_comb begin
    loClamped = (limLo < LIM_W'(LIM_FLOOR)) ? LIM_W'(LIM_FLOOR) : limLo;
    nextCnt   = cnt + CNT_W'(1);
    tickLive  = ctl.run & tickEn;
    edgeSeen  = tickLive & (syncBit ^ lastSample);
    inWindow  = (nextCnt >= {1'b0, loReg}) && (nextCnt < {1'b0, hiReg});
    st.tooLate  = tickLive & (nextCnt >= {1'b0, hiReg});
    st.goodEdge = edgeSeen & seenFirst & inWindow;
    st.badEdge  = edgeSeen & seenFirst & (nextCnt < {1'b0, loReg});
    st.enough   = ((halves + HALF_W'(1)) == target);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSample <= 1'b0;
      seenFirst  <= 1'b0;
      cnt        <= '0;
      halves     <= '0;
      target     <= '0;
      loReg      <= LIM_W'(LIM_FLOOR);
      hiReg      <= '0;
    end else if (ctl.load) begin
      lastSample <= syncBit;
      seenFirst  <= 1'b0;
      cnt        <= '0;
      halves     <= '0;
      target     <= halvesFor(bitSel);
      loReg      <= loClamped;
      hiReg      <= limHi;
    end else if (tickLive) begin
      lastSample <= syncBit;
      if (edgeSeen) begin
        cnt       <= '0;
        seenFirst <= 1'b1;
        if (st.goodEdge) halves <= halves + HALF_W'(1);
      end else begin
        cnt <= nextCnt;
      end
    end
  end

endmodule

// File: rtl/bitcheck_control.sv
module bitcheck_control
  import bitcheck_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] bitSel,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       pass,
  output logic       fail,
  output logic       done
);

  chkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (start) begin
      stateNext = (halvesFor(bitSel) == '0) ? ST_PASSED : ST_RUN;
    end else if (state == ST_RUN) begin
      if (st.tooLate || st.badEdge)
        stateNext = ST_FAILED;
      else if (st.goodEdge && st.enough)
        stateNext = ST_PASSED;
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;

  always_comb begin
    ctl.load = start;
    ctl.run  = (state == ST_RUN) && !start;
    pass     = (state == ST_PASSED);
    fail     = (state == ST_FAILED);
    done     = pass | fail;
  end

endmodule

// File: rtl/bitcheck_validator.sv
module bitcheck_validator
  import bitcheck_pkg::*;
#(
  parameter int LIM_W       = 6,
  parameter int LIM_FLOOR   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             dataIn,
  input  logic             start,
  input  logic [LIM_W-1:0] limLo,
  input  logic [LIM_W-1:0] limHi,
  input  logic [1:0]       bitSel,
  output logic             pass,
  output logic             fail,
  output logic             done
);

  ctlStrobe_t ctl;
  dpStatus_t  st;

  bitcheck_datapath #(
    .LIM_W(LIM_W), .LIM_FLOOR(LIM_FLOOR), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn),
    .limLo(limLo), .limHi(limHi), .bitSel(bitSel), .ctl(ctl), .st(st)
  );

  bitcheck_control ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .bitSel(bitSel), .st(st),
    .ctl(ctl), .pass(pass), .fail(fail), .done(done)
  );

endmodule

// File: rtl/bitcheck_validator_chk.sv
module bitcheck_validator_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       start,
  input logic [1:0] bitSel,
  input logic       pass,
  input logic       fail,
  input logic       done
);

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail)); // R11

  AST_ZERO_BITS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (start && bitSel == 2'b00) |=> (pass && done)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (start && bitSel != 2'b00) |=> !done); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(pass) && $stable(fail))); // R9

  AST_DONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && !$past(start)) |-> $past(tickEn)); // R10

endmodule

bind bitcheck_validator bitcheck_validator_chk chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .start(start), .bitSel(bitSel),
  .pass(pass), .fail(fail), .done(done)
);

// File: tb/bitcheck_validator_tb_top.sv
module bitcheck_validator_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       dataIn = 1'b0;
  logic       start = 1'b0;
  logic [5:0] limLo = 6'd14;
  logic [5:0] limHi = 6'd24;
  logic [1:0] bitSel = 2'b10;
  logic       pass, fail, done;

  int  checks = 0;
  int  failures = 0;
  int  phase = 0;
  bit  pauseTicks = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // Check-clock enable: one cycle in four unless paused
  always @(negedge clk) begin
    phase  = (phase + 1) % 4;
    tickEn = (phase == 3) && !pauseTicks;
  end

  bitcheck_validator dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn), .start(start),
    .limLo(limLo), .limHi(limHi), .bitSel(bitSel),
    .pass(pass), .fail(fail), .done(done)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Expected outcome: 0 pass, 1 fail
  function automatic int model(input int lo, input int hi, input int sel,
                               input int k0, input int ivals[$]);
    int loE, target, halves;
    loE    = (lo < 10) ? 10 : lo;  // R7
    target = sel * 6;              // R3
    if (target == 0) return 0;     // R2
    if (k0 + 1 >= hi) return 1;    // R6 before first edge
    halves = 0;
    foreach (ivals[i]) begin
      if (ivals[i] >= hi) return 1;  // R6
      if (ivals[i] < loE) return 1;  // R5
      halves++;                      // R4
      if (halves == target) return 0;
    end
    return 1;  // idle afterwards: timeout
  endfunction

  task automatic waitTicks(input int n);
    if (n > 0) begin
      repeat (n) begin
        do @(posedge clk); while (!tickEn);
      end
      @(negedge clk);
    end
  endtask

  task automatic pulseStart(input int lo, input int hi, input int sel);
    do @(posedge clk); while (!tickEn);
    @(negedge clk);
    limLo = 6'(lo); limHi = 6'(hi); bitSel = 2'(sel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCheck(input int lo, input int hi, input int sel, input int k0,
                          input int ivals[$], input bit doPause, input string req);
    int exp, got;
    exp = model(lo, hi, sel, k0, ivals);
    pulseStart(lo, hi, sel);
    if (sel != 0) begin
      waitTicks(k0);
      dataIn = ~dataIn;
      foreach (ivals[i]) begin
        if (done) break;
        if (doPause && i == 2 && ivals[i] > 5) begin
          waitTicks(5);
          pauseTicks = 1'b1;
          repeat (300) @(negedge clk);
          pauseTicks = 1'b0;
          waitTicks(ivals[i] - 5);
        end else begin
          waitTicks(ivals[i]);
        end
        dataIn = ~dataIn;
      end
      for (int t = 0; t < 70 && !done; t++) waitTicks(1);
    end
    got = fail ? 1 : (pass ? 0 : 2);
    check(got == exp && (done == (pass || fail)), req, got, exp);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int q[$];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!pass && !fail && !done, "R1 reset outputs", {pass, fail, done}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!done, "R1 idle after reset", done, 0);

    // R2 zero bits: result on the capturing edge
    bitSel = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(pass && done && !fail, "R2 zero-bit pass", {pass, fail}, 2);

    // R6 timeout timing, measured from start
    pulseStart(14, 24, 2);
    check(!done, "R9 start clears done", done, 0);
    waitTicks(23);
    check(!done, "R6 no result before high limit", done, 0);
    waitTicks(1);
    check(fail && !pass, "R6 fail at high limit", fail, 1);
    waitTicks(30);
    check(fail && !pass, "R9 result held", fail, 1);

    // R4 window boundaries, R3 counts
    q = {14, 23, 14, 23, 14, 23};
    runCheck(14, 24, 1, 3, q, 0, "R4 boundary intervals pass");
    q = {14, 23, 13};
    runCheck(14, 24, 1, 3, q, 0, "R5 short interval fails");
    q = {14, 24};
    runCheck(14, 24, 1, 3, q, 0, "R6 interval equal to high fails");
    q = {15, 15, 15, 15, 15};
    runCheck(14, 24, 1, 3, q, 0, "R3 five halves not enough");
    q = {};
    for (int i = 0; i < 18; i++) q.push_back(16);
    runCheck(14, 24, 3, 3, q, 0, "R3 nine bits pass");
    q = {};
    for (int i = 0; i < 11; i++) q.push_back(16);
    runCheck(14, 24, 2, 3, q, 0, "R3 six bits need twelve halves");
    // R7 clamp of low limit
    q = {10, 10, 10, 10, 10, 10};
    runCheck(3, 20, 1, 3, q, 0, "R7 clamped low accepts 10");
    q = {10, 9};
    runCheck(3, 20, 1, 3, q, 0, "R7 clamped low rejects 9");
    // R8 first edge unchecked
    q = {12, 12, 12, 12, 12, 12};
    runCheck(10, 16, 1, 0, q, 0, "R8 first edge not tested");
    // R10 pause in ticks
    runCheck(10, 16, 1, 2, q, 1, "R10 pause does not time out");
    // R9 restart mid-run
    pulseStart(14, 24, 2);
    waitTicks(5);
    pulseStart(14, 40, 0);
    check(pass && !fail, "R9 restart with new config", {pass, fail}, 2);

    // Random runs
    for (int r = 0; r < 30; r++) begin
      int lo, hi, sel, n, loE;
      lo  = 4 + int'($urandom % 20);
      hi  = 8 + int'($urandom % 33);
      sel = int'($urandom % 4);
      loE = (lo < 10) ? 10 : lo;
      n   = sel * 6 + int'($urandom % 2) - 1;
      q = {};
      for (int i = 0; i < n; i++) begin
        if ($urandom % 12 == 0 || hi <= loE + 1)
          q.push_back(1 + int'($urandom % 45));
        else
          q.push_back(loE + int'($urandom % (hi - loE)));
      end
      runCheck(lo, hi, sel, int'($urandom % 8), q, 0, "R4 random window run");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule